// File: doc/BRIEF.md
# Memory bit test unit

This unit carries out a bit-test instruction against one byte of data memory. On a start strobe it decodes the two instruction halfwords. It names the registers it needs and reads their contents from the core. It then forms a byte address and places a single byte read on a request/acknowledge memory port. It picks one bit of the returned byte and writes the Z flag with the inverse of that bit. No other flag exists in the unit, so no other flag can move.

Two encodings are accepted. In the displacement form the bit number (0 to 7) sits in the opcode, and the address is a base register plus a sign-extended 16-bit displacement taken from the second halfword. In the register form the address is the base register alone, and the bit number comes from the low three bits of a second register. Any other encoding is ignored. A zero-wait access finishes in three clocks. Each memory wait state adds one clock.

Top module: `bit_probe_unit`

## Requirements
- R1: Displacement form: first halfword bits [15:14] = 2'b11 and bits [10:5] = 6'b111110. The bit number is bits [13:11]. The read address is the base register contents plus the second halfword sign-extended to the word width.
- R2: Register form: first halfword bits [10:5] = 6'b111111 and the second halfword equal to 16'h00E6. The read address is the base register contents unchanged. The bit number is bits [2:0] of the index register contents, and its upper bits have no effect.
- R3: Bit number 0 selects the least significant bit of the byte read. At completion z_flag equals the logical NOT of the selected bit.
- R4: mem_req stays high with a constant mem_addr from the cycle after an accepted start until the cycle in which mem_ack is seen high, and it falls in the cycle after that.
- R5: done is a one-cycle pulse in the cycle after acknowledge. With no wait states done is high in the third cycle, counting the start cycle as the first. Each wait state delays done by one cycle.
- R6: After reset z_flag, mem_req and done are 0. z_flag changes only in a cycle where done is high.
- R7: A start with an encoding that matches neither form produces no memory request and no done, and leaves z_flag unchanged.
- R8: A start that arrives while an operation is in progress is ignored. The running request keeps its address, and no second operation follows it.
- R9: rs1_sel always equals first halfword bits [4:0] (base register). rs2_sel always equals bits [15:11] (index register for the register form).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation with the halfwords presented this cycle |
| instr_hw0 | input | 16 | First instruction halfword |
| instr_hw1 | input | 16 | Second instruction halfword |
| rs1_sel | output | 5 | Base register number to read |
| rs2_sel | output | 5 | Index register number to read |
| rs1_data | input | WORD_W | Base register contents |
| rs2_data | input | WORD_W | Index register contents |
| mem_req | output | 1 | Byte read request, held until acknowledge |
| mem_addr | output | WORD_W | Byte address of the read |
| mem_ack | input | 1 | Read acknowledge; mem_rdata valid with it |
| mem_rdata | input | 8 | Byte returned by memory |
| z_flag | output | 1 | Zero flag, NOT of the tested bit |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses negative displacements, so a design that zero-extends the displacement would read from an address 64 KiB too high. It tests bits 0 and 7 with values that catch a reversed bit order, and it gives the index register a large upper part, so a design that used more than three bits of that register would select the wrong bit. It inserts zero and several wait states while checking the request every cycle, so a design that dropped the request early or finished late would fail the cycle checks. It also sends invalid encodings and a second start while an operation is busy, so a design that launched a read for either would show an unexpected request or a changed Z.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  localparam int HW_W    = 16;
  localparam int BYTE_W  = 8;
  localparam int BIDX_W  = $clog2(BYTE_W);
  localparam int RSEL_W  = 5;

  localparam logic [5:0]      DISP_KEY = 6'b111110;
  localparam logic [5:0]      REG_KEY  = 6'b111111;
  localparam logic [HW_W-1:0] REG_TAIL = 16'h00E6;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_FIN} seq_state_t;

  function automatic logic is_disp_form(input logic [HW_W-1:0] hw0);
    return (hw0[15:14] == 2'b11) && (hw0[10:5] == DISP_KEY);
  endfunction

  function automatic logic is_reg_form(input logic [HW_W-1:0] hw0,
                                       input logic [HW_W-1:0] hw1);
    return (hw0[10:5] == REG_KEY) && (hw1 == REG_TAIL);
  endfunction

  function automatic logic pick_bit(input logic [BYTE_W-1:0] b,
                                    input logic [BIDX_W-1:0] idx);
    return b[idx];
  endfunction
endpackage

// File: rtl/bpu_decode.sv
module bpu_decode
  import bpu_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [HW_W-1:0]   hw0,
  input  logic [HW_W-1:0]   hw1,
  input  logic [WORD_W-1:0] base_val,
  input  logic [WORD_W-1:0] index_val,
  output logic [RSEL_W-1:0] base_sel,
  output logic [RSEL_W-1:0] index_sel,
  output logic              op_valid,
  output logic [WORD_W-1:0] eff_addr,
  output logic [BIDX_W-1:0] bit_idx
);
  localparam int EXT_W = WORD_W - HW_W;

  logic              disp_hit;
  logic              reg_hit;
  logic [WORD_W-1:0] disp_ext;
  logic              idx_unused;

  assign base_sel   = hw0[4:0];
  assign index_sel  = hw0[15:11];
  assign disp_hit   = is_disp_form(hw0);
  assign reg_hit    = is_reg_form(hw0, hw1);
  assign op_valid   = disp_hit | reg_hit;
  assign disp_ext   = {{EXT_W{hw1[HW_W-1]}}, hw1};
  assign idx_unused = ^index_val[WORD_W-1:BIDX_W];

  always_comb begin
    if (disp_hit) begin
      eff_addr = base_val + disp_ext;
      bit_idx  = hw0[13:11];
    end else begin
      eff_addr = base_val;
      bit_idx  = index_val[BIDX_W-1:0];
    end
  end

  always_comb begin
    assert (!(disp_hit && reg_hit)) else $error("assert_forms_disjoint_R1: both forms matched");
  end
endmodule

// File: rtl/bpu_seq.sv
module bpu_seq
  import bpu_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_valid,
  input  logic [WORD_W-1:0] addr_in,
  input  logic [BIDX_W-1:0] bit_in,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic [WORD_W-1:0] mem_addr,
  output logic [BIDX_W-1:0] bit_q,
  output logic              capture,
  output logic              done
);
  seq_state_t state;
  logic       accept;
  logic       reject;

  assign accept  = (state == ST_IDLE) && start && op_valid;
  assign reject  = (state == ST_IDLE) && start && !op_valid;
  assign mem_req = (state == ST_REQ);
  assign capture = mem_req && mem_ack;
  assign done    = (state == ST_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      mem_addr <= '0;
      bit_q    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_REQ;
          mem_addr <= addr_in;
          bit_q    <= bit_in;
        end
        ST_REQ:  if (mem_ack) state <= ST_FIN;
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  assert_req_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req);
  assert_done_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> done);
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_bad_op_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> !mem_req);
  assert_busy_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !mem_req);
endmodule

// File: rtl/bpu_zsel.sv
module bpu_zsel
  import bpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [BYTE_W-1:0] rdata,
  input  logic [BIDX_W-1:0] bit_q,
  input  logic              done,
  output logic              z_flag
);
  logic tested_bit;

  assign tested_bit = pick_bit(rdata, bit_q);

  always_ff @(posedge clk) begin
    if (!rst_n)       z_flag <= 1'b0;
    else if (capture) z_flag <= ~tested_bit;
  end

  assert_z_only_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(z_flag));
  assert_z_inverse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (z_flag != $past(rdata[bit_q])));
endmodule

// File: rtl/bit_probe_unit.sv
module bit_probe_unit
  import bpu_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       instr_hw0,
  input  logic [15:0]       instr_hw1,
  output logic [4:0]        rs1_sel,
  output logic [4:0]        rs2_sel,
  input  logic [WORD_W-1:0] rs1_data,
  input  logic [WORD_W-1:0] rs2_data,
  output logic              mem_req,
  output logic [WORD_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata,
  output logic              z_flag,
  output logic              done
);
  logic              op_valid;
  logic [WORD_W-1:0] eff_addr;
  logic [BIDX_W-1:0] bit_idx;
  logic [BIDX_W-1:0] bit_q;
  logic              capture;

  bpu_decode #(.WORD_W(WORD_W)) u_decode (
    .hw0       (instr_hw0),
    .hw1       (instr_hw1),
    .base_val  (rs1_data),
    .index_val (rs2_data),
    .base_sel  (rs1_sel),
    .index_sel (rs2_sel),
    .op_valid  (op_valid),
    .eff_addr  (eff_addr),
    .bit_idx   (bit_idx)
  );

  bpu_seq #(.WORD_W(WORD_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op_valid (op_valid),
    .addr_in  (eff_addr),
    .bit_in   (bit_idx),
    .mem_ack  (mem_ack),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .bit_q    (bit_q),
    .capture  (capture),
    .done     (done)
  );

  bpu_zsel u_zsel (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .rdata   (mem_rdata),
    .bit_q   (bit_q),
    .done    (done),
    .z_flag  (z_flag)
  );
endmodule

// File: tb/bit_probe_unit_tb.sv
`timescale 1ns/1ps
module bit_probe_unit_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [15:0]  instr_hw0 = '0;
  logic [15:0]  instr_hw1 = '0;
  logic [4:0]   rs1_sel;
  logic [4:0]   rs2_sel;
  logic [W-1:0] rs1_data = '0;
  logic [W-1:0] rs2_data = '0;
  logic         mem_req;
  logic [W-1:0] mem_addr;
  logic         mem_ack = 1'b0;
  logic [7:0]   mem_rdata = '0;
  logic         z_flag;
  logic         done;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  bit_probe_unit #(.WORD_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .instr_hw0(instr_hw0), .instr_hw1(instr_hw1),
    .rs1_sel(rs1_sel), .rs2_sel(rs2_sel),
    .rs1_data(rs1_data), .rs2_data(rs2_data),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .z_flag(z_flag), .done(done)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] enc_disp(input logic [2:0] b, input logic [4:0] r1);
    return {2'b11, b, 6'b111110, r1};
  endfunction
  function automatic logic [15:0] enc_reg(input logic [4:0] r2, input logic [4:0] r1);
    return {r2, 6'b111111, r1};
  endfunction

  task automatic step;
    @(negedge clk);
  endtask

  // Full operation: start cycle, request for 1+waits cycles, then done cycle.
  task automatic run_op(input string req, input logic [15:0] h0, input logic [15:0] h1,
                        input logic [W-1:0] r1, input logic [W-1:0] r2,
                        input logic [7:0] mbyte, input int waits,
                        input logic [W-1:0] exp_addr, input logic exp_z);
    logic z_before;
    z_before = z_flag;
    instr_hw0 = h0; instr_hw1 = h1; rs1_data = r1; rs2_data = r2; start = 1'b1;
    #0.1;
    check({req, " R9 rs1_sel"}, W'(rs1_sel), W'(h0[4:0]));
    check({req, " R9 rs2_sel"}, W'(rs2_sel), W'(h0[15:11]));
    step(); start = 1'b0;
    for (int i = 0; i < waits; i++) begin
      check({req, " R4 req during wait"}, W'(mem_req), 1);
      check({req, " R4 addr"}, mem_addr, exp_addr);
      check({req, " R5 no early done"}, W'(done), 0);
      check({req, " R6 z held"}, W'(z_flag), W'(z_before));
      step();
    end
    check({req, " R4 req at ack"}, W'(mem_req), 1);
    check({req, " R1/R2 addr"}, mem_addr, exp_addr);
    mem_ack = 1'b1; mem_rdata = mbyte;
    step(); mem_ack = 1'b0; mem_rdata = 8'hxx;
    check({req, " R5 done"}, W'(done), 1);
    check({req, " R3 z"}, W'(z_flag), W'(exp_z));
    check({req, " R4 req dropped"}, W'(mem_req), 0);
    step();
    check({req, " R5 done pulse"}, W'(done), 0);
  endtask

  task automatic t_reset;
    check("R6 reset z", W'(z_flag), 0);
    check("R6 reset req", W'(mem_req), 0);
    check("R6 reset done", W'(done), 0);
  endtask

  task automatic t_disp;
    // positive displacement, bit 0, bit set -> z=0
    run_op("R1 disp+", enc_disp(3'd0, 5'd3), 16'h0010, 32'h0000_1000, 32'h0, 8'h01, 0,
           32'h0000_1010, 1'b0);
    // negative displacement, bit 7, bit clear -> z=1
    run_op("R1 disp-", enc_disp(3'd7, 5'd9), 16'hFFF0, 32'h0000_2000, 32'h0, 8'h7F, 2,
           32'h0000_1FF0, 1'b1);
    // bit 5 set among others clear -> z=0
    run_op("R3 bit5", enc_disp(3'd5, 5'd1), 16'h8000, 32'h0001_0000, 32'h0, 8'h20, 1,
           32'h0000_8000, 1'b0);
  endtask

  task automatic t_reg;
    // index upper bits large, low bits = 3; byte has only bit 3 clear -> z=1
    run_op("R2 reg", enc_reg(5'd4, 5'd2), 16'h00E6, 32'hABCD_0001, 32'hFFFF_FFF3, 8'hF7, 0,
           32'hABCD_0001, 1'b1);
    // index 0 -> LSB; byte 0xFE -> z=1
    run_op("R3 lsb", enc_reg(5'd6, 5'd7), 16'h00E6, 32'h0000_0040, 32'h0000_0008, 8'hFE, 3,
           32'h0000_0040, 1'b1);
    run_op("R3 msb", enc_reg(5'd6, 5'd7), 16'h00E6, 32'h0000_0041, 32'h0000_0107, 8'h80, 0,
           32'h0000_0041, 1'b0);
  endtask

  task automatic t_invalid;
    logic z_before;
    z_before = z_flag;
    // register-form key but wrong second halfword
    instr_hw0 = enc_reg(5'd1, 5'd1); instr_hw1 = 16'h00E7; start = 1'b1;
    step();
    // displacement key with bits 15:14 not 11
    instr_hw0 = {2'b01, 3'd2, 6'b111110, 5'd1}; instr_hw1 = 16'h0;
    step(); start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check("R7 no req", W'(mem_req), 0);
      check("R7 no done", W'(done), 0);
      check("R7 z unchanged", W'(z_flag), W'(z_before));
      step();
    end
  endtask

  task automatic t_busy;
    instr_hw0 = enc_disp(3'd1, 5'd2); instr_hw1 = 16'h0004;
    rs1_data = 32'h0000_0100; start = 1'b1;
    step();
    // second start while request is waiting
    instr_hw0 = enc_disp(3'd2, 5'd2); instr_hw1 = 16'h0200;
    rs1_data = 32'h0000_5000;
    step(); step();
    check("R8 addr kept", mem_addr, 32'h0000_0104);
    start = 1'b0;
    mem_ack = 1'b1; mem_rdata = 8'h02;
    step(); mem_ack = 1'b0;
    check("R8 done", W'(done), 1);
    check("R8 z from first op", W'(z_flag), 0);
    step();
    check("R8 no second op", W'(mem_req), 0);
    step();
    check("R8 no second op later", W'(mem_req), 0);
  endtask

  initial begin
    step(); step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_disp();
    t_reg();
    t_invalid();
    t_busy();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #400000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule